// File: doc/BRIEF.md
# Sector DMA Engine for a Flash Card Data Port

This block copies one 512-byte sector between system RAM and the data register of a CompactFlash card, in either direction, without the processor touching each byte. Software first sets up the card's task file: the sector address, a count of one, the read or write command, and a wait for ready. It then writes a single command byte to the engine. The seven upper bits of that byte select a 512-byte-aligned region of memory. The lowest bit selects the direction.

From the next clock edge the engine holds the processor. It drops the processor's bus-enable and ready lines and drives the memory address and all strobes itself. It moves one byte per two clocks. Each byte slot has a first half and a second half:

- In the first half, a byte is read from the card, or memory drives the bus.
- In the second half, that byte is written into memory or into the card.

After the 512th slot the engine gives the bus back and is ready for the next command. To the processor, the whole sector has moved between two instructions.

Top module: `sdma_engine`

## Requirements
- R1: While reset is asserted, and right after reset, busy is 0, cpu_be and cpu_rdy are 1, cf_rd_n, cf_wr_n, mem_we_n and mem_rw_n are all 1, and mem_addr is 0.
- R2: A cycle with cmd_we high while idle starts a transfer. From the next cycle, busy is 1 and mem_addr equals {cmd_data[7:1], 9'd0}. A command written in the first idle cycle after a transfer is accepted.
- R3: During a transfer, mem_addr[15:9] holds the page from the command, and mem_addr[8:0] is the byte index. The index starts at 0 and rises by one every two clock cycles.
- R4: A transfer keeps busy high for exactly 1024 cycles, which is 512 byte slots. The last slot addresses {page, 9'h1FF}. In the cycle after that, busy is 0.
- R5: cpu_be and cpu_rdy are 0 exactly in the cycles where busy is 1, and 1 otherwise.
- R6: When cmd_data[0] was 1 (card to memory), mem_rw_n is 0 for the whole transfer and cf_wr_n stays 1. cf_rd_n is 0 in the first half of each slot, and mem_we_n is 0 in the second half.
- R7: When cmd_data[0] was 0 (memory to card), mem_rw_n stays 1 for the whole transfer, and cf_rd_n and mem_we_n stay 1. cf_wr_n is 0 in the second half of each slot only.
- R8: A card strobe (cf_rd_n or cf_wr_n low) is never low in the same cycle as mem_we_n. All four strobe outputs are 1 whenever busy is 0.
- R9: A cmd_we pulse during a transfer is ignored. The page and direction in use do not change, and the transfer ends at the same cycle as it would without the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Engine clock, twice the byte rate |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Processor write to the command latch |
| cmd_data | input | 8 | Command byte: [7:1] page, [0] direction (1 = card to memory) |
| mem_addr | output | 16 | Memory address, {page, byte index} |
| mem_rw_n | output | 1 | Memory read (1) / write (0) level |
| mem_we_n | output | 1 | Active-low memory write pulse |
| cf_rd_n | output | 1 | Active-low card read strobe |
| cf_wr_n | output | 1 | Active-low card write strobe |
| cpu_be | output | 1 | Processor bus enable, 0 while the engine owns the bus |
| cpu_rdy | output | 1 | Processor ready, 0 halts the processor |
| busy | output | 1 | 1 while a transfer is running |

## Verification
A command sampled at clock edge E shows its effect from the cycle after E. Call that cycle k = 0. In cycle k, which lies between edges E+k and E+k+1, the byte index is k/2 and the half is k mod 2. The first cycle with busy at 0 is k = 1024.

The bench drives the command one half period before E. It then compares every output at each falling edge against functions of k, the page and the direction. The cycle at k = 1024 is always one of the compared cycles.

Writes injected during a transfer, at random k, are checked through the same per-cycle address and strobe comparisons. Each new command is issued in the first idle cycle, which exercises back-to-back acceptance.

// File: rtl/sdma_pkg.sv
package sdma_pkg;

  typedef enum logic {
    XFER_TO_CF   = 1'b0,
    XFER_FROM_CF = 1'b1
  } xfer_dir_e;

  typedef enum logic {
    HALF_SOURCE = 1'b0,
    HALF_SINK   = 1'b1
  } half_e;

  typedef struct packed {
    logic cf_rd_n;
    logic cf_wr_n;
    logic mem_rw_n;
    logic mem_we_n;
  } strobe_t;

  localparam strobe_t STROBE_IDLE = '{cf_rd_n: 1'b1, cf_wr_n: 1'b1,
                                      mem_rw_n: 1'b1, mem_we_n: 1'b1};

  // Strobe pattern for one cycle of a byte slot.
  function automatic strobe_t decode_strobes(input logic active,
                                             input half_e half,
                                             input xfer_dir_e dir);
    strobe_t s;
    s = STROBE_IDLE;
    if (active) begin
      if (dir == XFER_FROM_CF) begin
        s.mem_rw_n = 1'b0;
        if (half == HALF_SOURCE) s.cf_rd_n  = 1'b0;
        else                     s.mem_we_n = 1'b0;
      end else if (half == HALF_SINK) begin
        s.cf_wr_n = 1'b0;
      end
    end
    return s;
  endfunction

endpackage

// File: rtl/sdma_cmd_latch.sv
module sdma_cmd_latch
  import sdma_pkg::*;
#(
  parameter int PAGE_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [PAGE_W:0]   cmd_data,
  output logic [PAGE_W-1:0] page,
  output xfer_dir_e         dir
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page <= '0;
      dir  <= XFER_TO_CF;
    end else if (load) begin
      page <= cmd_data[PAGE_W:1];
      dir  <= xfer_dir_e'(cmd_data[0]);
    end
  end

endmodule

// File: rtl/sdma_slot_seq.sv
module sdma_slot_seq
  import sdma_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output half_e            half,
  output logic [CNT_W-1:0] count,
  output logic             slot_end,
  output logic             last_slot
);

  localparam logic [CNT_W-1:0] LAST_IDX = {CNT_W{1'b1}};

  function automatic logic [CNT_W-1:0] next_index(input logic [CNT_W-1:0] c);
    return c + 1'b1;
  endfunction

  assign slot_end  = busy && (half == HALF_SINK);
  assign last_slot = (count == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      half  <= HALF_SOURCE;
      count <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      half  <= HALF_SOURCE;
      count <= '0;
    end else if (busy) begin
      half <= (half == HALF_SOURCE) ? HALF_SINK : HALF_SOURCE;
      if (slot_end) begin
        if (last_slot) begin
          busy <= 1'b0;
          half <= HALF_SOURCE;
        end else begin
          count <= next_index(count);
        end
      end
    end
  end

endmodule

// File: rtl/sdma_strobe_gen.sv
module sdma_strobe_gen
  import sdma_pkg::*;
(
  input  logic      busy,
  input  half_e     half,
  input  xfer_dir_e dir,
  output logic      cf_rd_n,
  output logic      cf_wr_n,
  output logic      mem_rw_n,
  output logic      mem_we_n
);

  strobe_t strb;

  always_comb strb = decode_strobes(busy, half, dir);

  assign cf_rd_n  = strb.cf_rd_n;
  assign cf_wr_n  = strb.cf_wr_n;
  assign mem_rw_n = strb.mem_rw_n;
  assign mem_we_n = strb.mem_we_n;

endmodule

// File: rtl/sdma_engine.sv
module sdma_engine
  import sdma_pkg::*;
#(
  parameter int PAGE_W = 7,
  parameter int CNT_W  = 9,
  localparam int CMD_W  = PAGE_W + 1,
  localparam int ADDR_W = PAGE_W + CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we,
  input  logic [CMD_W-1:0]  cmd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rw_n,
  output logic              mem_we_n,
  output logic              cf_rd_n,
  output logic              cf_wr_n,
  output logic              cpu_be,
  output logic              cpu_rdy,
  output logic              busy
);

  function automatic logic [ADDR_W-1:0] join_addr(input logic [PAGE_W-1:0] pg,
                                                  input logic [CNT_W-1:0]  idx);
    return {pg, idx};
  endfunction

  // Named internal events, also used by the bound checker.
  logic              cmd_accept;
  logic              slot_end;
  logic              last_slot;
  half_e             half;
  xfer_dir_e         xfer_dir;
  logic [PAGE_W-1:0] page;
  logic [CNT_W-1:0]  byte_idx;

  assign cmd_accept = cmd_we && !busy;

  sdma_cmd_latch #(.PAGE_W(PAGE_W)) u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cmd_accept),
    .cmd_data (cmd_data),
    .page     (page),
    .dir      (xfer_dir)
  );

  sdma_slot_seq #(.CNT_W(CNT_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (cmd_accept),
    .busy      (busy),
    .half      (half),
    .count     (byte_idx),
    .slot_end  (slot_end),
    .last_slot (last_slot)
  );

  sdma_strobe_gen u_strb (
    .busy     (busy),
    .half     (half),
    .dir      (xfer_dir),
    .cf_rd_n  (cf_rd_n),
    .cf_wr_n  (cf_wr_n),
    .mem_rw_n (mem_rw_n),
    .mem_we_n (mem_we_n)
  );

  assign mem_addr = join_addr(page, byte_idx);
  assign cpu_be   = !busy;
  assign cpu_rdy  = !busy;

endmodule

// File: rtl/sdma_engine_chk.sv
module sdma_engine_chk #(
  parameter int PAGE_W = 7,
  parameter int CNT_W  = 9,
  localparam int ADDR_W = PAGE_W + CNT_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_we,
  input logic [PAGE_W:0]   cmd_data,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_rw_n,
  input logic              mem_we_n,
  input logic              cf_rd_n,
  input logic              cf_wr_n,
  input logic              cpu_be,
  input logic              cpu_rdy,
  input logic              busy,
  input logic              slot_end,
  input logic              last_slot,
  input logic              xfer_dir
);

  a_r2_start_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_we) |=> (busy && mem_addr == {$past(cmd_data[PAGE_W:1]), {CNT_W{1'b0}}}));

  a_r3_index_step: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_end && !last_slot) |=> (mem_addr == ADDR_W'($past(mem_addr) + 1)));

  a_r9_page_held: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || $stable(mem_addr[ADDR_W-1:CNT_W])));

  a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_end && last_slot) |=> !busy);

  a_r5_cpu_held: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_be == !busy) && (cpu_rdy == !busy));

  a_r6_from_card_level: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && xfer_dir) |-> (!mem_rw_n && cf_wr_n));

  a_r6_from_card_store: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_end && xfer_dir) |-> (!mem_we_n && cf_rd_n));

  a_r7_to_card_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !xfer_dir) |-> (mem_rw_n && cf_rd_n && mem_we_n));

  a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !((!cf_rd_n || !cf_wr_n) && !mem_we_n));

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cf_rd_n && cf_wr_n && mem_we_n && mem_rw_n));

endmodule

bind sdma_engine sdma_engine_chk #(.PAGE_W(PAGE_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_we    (cmd_we),
  .cmd_data  (cmd_data),
  .mem_addr  (mem_addr),
  .mem_rw_n  (mem_rw_n),
  .mem_we_n  (mem_we_n),
  .cf_rd_n   (cf_rd_n),
  .cf_wr_n   (cf_wr_n),
  .cpu_be    (cpu_be),
  .cpu_rdy   (cpu_rdy),
  .busy      (busy),
  .slot_end  (slot_end),
  .last_slot (last_slot),
  .xfer_dir  (xfer_dir)
);

// File: tb/sim_sdma_engine.sv
`timescale 1ns/1ps
module sim_sdma_engine;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_we = 1'b0;
  logic [7:0]  cmd_data = 8'h00;
  logic [15:0] mem_addr;
  logic        mem_rw_n, mem_we_n, cf_rd_n, cf_wr_n, cpu_be, cpu_rdy, busy;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sdma_engine u0 (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_data(cmd_data),
    .mem_addr(mem_addr), .mem_rw_n(mem_rw_n), .mem_we_n(mem_we_n),
    .cf_rd_n(cf_rd_n), .cf_wr_n(cf_wr_n), .cpu_be(cpu_be),
    .cpu_rdy(cpu_rdy), .busy(busy)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Expected address in cycle k of a transfer: page times 512 plus slot number.
  function automatic logic [15:0] want_addr(input logic [7:0] cmd, input int k);
    return 16'((int'(cmd) / 2) * 512 + k / 2);
  endfunction

  // Expected strobes {cf_rd_n, cf_wr_n, mem_rw_n, mem_we_n} in cycle k.
  function automatic logic [3:0] want_strobes(input logic [7:0] cmd, input int k);
    bit second = (k % 2) == 1;
    if (cmd[0]) return {second, 1'b1, 1'b0, !second};
    return {1'b1, !second, 1'b1, 1'b1};
  endfunction

  task automatic chk_idle(input string req);
    chk({req, " busy/be/rdy"}, {29'd0, busy, cpu_be, cpu_rdy}, 32'b011);
    chk({req, " strobes idle R8"}, {28'd0, cf_rd_n, cf_wr_n, mem_rw_n, mem_we_n}, 32'hF);
  endtask

  // Issue cmd in the current idle cycle; optionally inject a write at cycle inj_k.
  task automatic run_xfer(input logic [7:0] cmd, input int inj_k, input logic [7:0] inj);
    chk_idle("R2 pre-start");
    cmd_we = 1'b1;
    cmd_data = cmd;
    @(posedge clk);
    for (int k = 0; k < 1024; k++) begin
      @(negedge clk);
      chk("R4 R5 busy/be/rdy", {29'd0, busy, cpu_be, cpu_rdy}, 32'b100);
      chk("R2 R3 R9 mem_addr", {16'd0, mem_addr}, {16'd0, want_addr(cmd, k)});
      chk(cmd[0] ? "R6 R8 strobes" : "R7 R8 strobes",
          {28'd0, cf_rd_n, cf_wr_n, mem_rw_n, mem_we_n}, {28'd0, want_strobes(cmd, k)});
      cmd_we = (k == inj_k);
      if (k == inj_k) cmd_data = inj;
    end
    @(negedge clk);
    chk_idle("R4 R5 after end");
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk_idle("R1 in reset");
    chk("R1 addr in reset", {16'd0, mem_addr}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("R1 after reset");
    chk("R1 addr after reset", {16'd0, mem_addr}, 32'd0);
    // Directed corners: lowest page from card, highest page to card, injects at edges.
    run_xfer(8'h01, -1, 8'h00);
    run_xfer(8'hFE, 0, 8'h55);
    run_xfer(8'hFF, 1022, 8'h02);
    run_xfer(8'h00, 1023, 8'hAB);
    for (int n = 0; n < 8; n++) begin
      logic [7:0] c = 8'($urandom);
      logic [7:0] x = 8'($urandom);
      int ik = ($urandom % 3 == 0) ? -1 : int'($urandom % 1024);
      run_xfer(c, ik, x);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule